// File: doc/BRIEF.md
# Audio master clock ratio generator

This block turns a fast reference clock into a square-wave master clock for a serial audio port. The reference clock runs at twice a fixed base rate. The base rate is either 512 times or 384 times the audio sample rate. A one-bit family select says which base applies. A small code then picks the master clock ratio within that family, as a power-of-two division of the base. This covers ratios from 32x to 512x at any sample rate from 8 kHz to 192 kHz, because the reference clock tracks the sample rate.

Software writes a run bit and a gate bit. The output runs while run is set and gate is clear. A ratio code that the selected family cannot reach is flagged and never loaded. Ratio changes and stops are deferred to period boundaries, so the output never shows a runt pulse.

Top module: `mclk_ratio_gen`

## Requirements
- R1: While reset is asserted and after it is released, mclk_out is low until the output is enabled.
- R2: With fam384 = 0, ratio codes 4, 3, 2, 1 and 0 give 512x, 256x, 128x, 64x and 32x. The output period is 1024/ratio cycles of clk: 2, 4, 8, 16 or 32 cycles.
- R3: With fam384 = 1, ratio codes 3, 2, 1 and 0 give 384x, 192x, 96x and 48x. The output period is 768/ratio cycles of clk: 2, 4, 8 or 16 cycles.
- R4: ratio_bad is high, combinationally, exactly when the code exceeds 4 with fam384 = 0, or exceeds 3 with fam384 = 1.
- R5: A flagged code is never applied. While running, the last good ratio is kept. From idle, the output does not start and stays low.
- R6: Every period is high for exactly half its cycles and then low for the other half.
- R7: A new ratio takes effect only at the rising edge that begins the next period, after the current low phase has completed.
- R8: The output is enabled when run = 1 and gate = 0. From idle, mclk_out goes high at the first clock edge that samples the output enabled with a good code.
- R9: When run is cleared, the current period completes, including its full low phase, and mclk_out then stays low.
- R10: Setting gate stops the output in the same way as clearing run, even with run still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock at twice the base rate |
| rst_n | input | 1 | Active-low synchronous reset |
| fam384 | input | 1 | Family select: 0 = 512x base, 1 = 384x base |
| ratio_code | input | 3 | Ratio code within the family |
| run | input | 1 | Output enable request |
| gate | input | 1 | Clock gate: stops the output when set |
| mclk_out | output | 1 | Master clock output, 50 percent duty |
| ratio_bad | output | 1 | Current family and code form an unreachable ratio |

## Verification
The bench steps a behavioural model of periods and phases, derived from the ratio table, and compares it every cycle. It changes the ratio in the middle of a high phase. A design that applied the change at once would produce a short high pulse.

It also stops the output partway through a period. A design that stopped at once would leave a runt pulse. A design that restarted too soon would leave a shortened low phase.

Unreachable codes are applied both while running and from idle. A design that loaded such a code would switch to a wrong period, or would start when it should stay low. All sixteen family and code pairs are checked against the flag.

// File: rtl/mclk_ratio_gen.sv
module mclk_ratio_gen #(
  parameter int MULT_W    = 3,
  parameter int MAX_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fam384,
  input  logic [MULT_W-1:0] ratio_code,
  input  logic              run,
  input  logic              gate,
  output logic              mclk_out,
  output logic              ratio_bad
);
  localparam int CNT_W = MAX_SHIFT;

  logic [MULT_W-1:0] top_code, shift_req;
  logic [CNT_W-1:0]  last_req, last_q, cnt;
  logic              active, mclk_q, enable;

  assign top_code  = fam384 ? MULT_W'(MAX_SHIFT - 1) : MULT_W'(MAX_SHIFT);
  assign ratio_bad = ratio_code > top_code;
  assign shift_req = top_code - ratio_code;
  assign last_req  = {CNT_W{1'b1}} >> (MULT_W'(MAX_SHIFT) - shift_req);
  assign enable    = run & ~gate;
  assign mclk_out  = mclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      mclk_q <= 1'b0;
      cnt    <= '0;
      last_q <= '0;
    end else if (!active) begin
      cnt <= '0;
      if (enable && !ratio_bad) begin
        active <= 1'b1;
        mclk_q <= 1'b1;
        last_q <= last_req;
      end
    end else if (cnt == last_q) begin
      cnt <= '0;
      if (mclk_q) begin
        mclk_q <= 1'b0;
      end else if (!enable) begin
        active <= 1'b0;
      end else begin
        mclk_q <= 1'b1;
        if (!ratio_bad) last_q <= last_req;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !mclk_q);

  a_r4_flag_range: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_bad |-> (ratio_code >= MULT_W'(MAX_SHIFT)));

  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt <= last_q));

  a_r7_hold_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$rose(mclk_q)) |-> $stable(last_q));

  a_r8_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && enable && !ratio_bad) |=> (active && mclk_q));

  a_r5_no_bad_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && ratio_bad) |=> !mclk_q);
endmodule

// File: tb/mclk_ratio_gen_bench.sv
module mclk_ratio_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fam384 = 1'b0;
  logic [2:0] ratio_code = 3'd0;
  logic       run = 1'b0;
  logic       gate = 1'b0;
  logic       mclk_out, ratio_bad;

  int    n_run = 0, n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  bit m_active = 1'b0, m_out = 1'b0;
  int m_half = 0, m_pos = 0;

  always #2 clk = ~clk;

  mclk_ratio_gen u_mclk_ratio_gen (
    .clk(clk), .rst_n(rst_n), .fam384(fam384), .ratio_code(ratio_code),
    .run(run), .gate(gate), .mclk_out(mclk_out), .ratio_bad(ratio_bad)
  );

  function automatic bit code_ok(bit f, int c);
    return f ? (c <= 3) : (c <= 4);
  endfunction

  function automatic int half_of(bit f, int c);
    int ratio, base;
    base  = f ? 384 : 512;
    ratio = (f ? 48 : 32) << c;
    return base / ratio;
  endfunction

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit en;
    en = run && !gate;
    if (!rst_n) begin
      m_active = 0; m_out = 0; m_pos = 0;
    end else if (!m_active) begin
      if (en && code_ok(fam384, ratio_code)) begin
        m_active = 1; m_out = 1; m_pos = 0;
        m_half = half_of(fam384, ratio_code);
      end
    end else begin
      m_pos++;
      if (m_pos == m_half) begin
        m_pos = 0;
        if (m_out) m_out = 0;
        else if (!en) m_active = 0;
        else begin
          m_out = 1;
          if (code_ok(fam384, ratio_code)) m_half = half_of(fam384, ratio_code);
        end
      end
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_step();
      #1;
      check(cur_req, mclk_out, m_out);
    end
  endtask

  initial begin
    cur_req = "R1";
    tick(3);
    rst_n = 1'b1;
    tick(5);

    cur_req = "R8";
    run = 1'b1; fam384 = 1'b0; ratio_code = 3'd0;
    tick(1);
    check("R8", mclk_out, 1);
    cur_req = "R2";
    tick(70);
    for (int c = 4; c >= 1; c--) begin
      ratio_code = 3'(c);
      tick(37);
    end

    cur_req = "R7";
    ratio_code = 3'd0;
    tick(5);
    ratio_code = 3'd3;
    tick(3);
    ratio_code = 3'd1;
    tick(40);

    cur_req = "R9";
    ratio_code = 3'd0;
    tick(20);
    run = 1'b0;
    tick(60);
    check("R9", mclk_out, 0);

    cur_req = "R10";
    run = 1'b1;
    tick(45);
    gate = 1'b1;
    tick(50);
    check("R10", mclk_out, 0);
    gate = 1'b0;

    cur_req = "R3";
    fam384 = 1'b1;
    for (int c = 3; c >= 0; c--) begin
      ratio_code = 3'(c);
      tick(41);
    end

    cur_req = "R5";
    ratio_code = 3'd4;
    tick(40);
    run = 1'b0;
    tick(40);
    ratio_code = 3'd7;
    run = 1'b1;
    tick(30);
    check("R5", mclk_out, 0);

    cur_req = "R6";
    ratio_code = 3'd2;
    tick(50);
    fam384 = 1'b0;
    tick(50);

    for (int f = 0; f < 2; f++) begin
      for (int c = 0; c < 8; c++) begin
        fam384 = f[0]; ratio_code = 3'(c);
        #1;
        check("R4", ratio_bad, !code_ok(f[0], c));
      end
    end

    cur_req = "R1";
    rst_n = 1'b0;
    tick(3);
    check("R1", mclk_out, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule